// File: doc/BRIEF.md
# Raster Sync Timing Generator with LFSR Counters

This block paces a monochrome raster display of 576 by 455 pixels at sync rates a VGA monitor accepts. Each clock stands for two displayed pixels. The block counts clocks within a line and lines within a frame. From those counts it drives a horizontal sync, a vertical sync, a horizontal enable and a vertical enable. It also gives a one-clock frame-start strobe that the pixel fetch logic uses to rewind its address.

Neither position counter is a binary counter. Each is a shift register whose serial input is the XOR of two output taps, with tap sets chosen so that the register cycles through all nonzero states. The default widths are 9 bits for the pixel-pair counter and 10 bits for the line counter. Every timing mark is matched against an LFSR state. That state is computed at elaboration by stepping the register forward from its seed, so the comparators stay simple equality tests. The line counter moves only on the clock where the pixel-pair counter wraps. All marks are parameters. Sync polarity is active high.

Position (h, v) means h clocks into the current line and v lines into the current frame. Both are zero on the first clock after reset.

Top module: `raster_sync_gen`

## Requirements
- R1: A synchronous active-high reset puts the block at position (0, 0): h_active=1, v_active=1, video_on=1, hsync=0, vsync=0, frame_start=0. These values hold while reset is high and on the first clock after it is released.
- R2: h_active is 1 for h from 0 to H_ACTIVE-1 (287 by default) and 0 for the rest of the line.
- R3: hsync is 1 for h from H_SYNC_START to H_SYNC_END-1 (308 to 352 by default) and 0 elsewhere.
- R4: A line lasts H_TOTAL clocks (381 by default). After h = H_TOTAL-1 the next clock is h=0 of the next line, and h_active is 1 again.
- R5: v advances by one exactly when h wraps. v_active is 1 for v from 0 to V_ACTIVE-1 (454 by default) and 0 otherwise.
- R6: vsync is 1 for lines V_SYNC_START to V_SYNC_END-1 (486 and 487 by default) and 0 elsewhere.
- R7: A frame lasts V_TOTAL lines (528 by default). frame_start is 1 for exactly one clock, at position (0, 0) of every frame that follows a wrap from the last clock of the previous frame. It is not raised at the origin reached through reset.
- R8: video_on is 1 exactly when h_active and v_active are both 1.
- R9: Asserting reset in the middle of a frame restarts timing from position (0, 0), and all later marks follow from that restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one tick per displayed pixel pair |
| rst | input | 1 | Synchronous active-high reset |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| h_active | output | 1 | Horizontal display enable |
| v_active | output | 1 | Vertical display enable |
| video_on | output | 1 | Both enables true |
| frame_start | output | 1 | One-clock strobe at the origin of each new frame |

## Verification
The main instance uses a reduced timing set: 20-clock lines and 11-line frames. This lets the bench compare every clock of several whole frames against positions derived from a running cycle count. A full sweep like this catches a mark placed one clock early or late and a wrong line length. It also catches a line counter that advances on the wrong clock or a frame strobe raised on the wrong position. A second instance keeps the default timing and runs for more than three lines. That run shows that the LFSR states computed from the real marks (288, 308, 353, 381) land on the correct clocks. A reset applied mid-frame, followed by another sweep, tells a true restart apart from a counter that only freezes.

// File: rtl/raster_pkg.sv
package raster_pkg;

    localparam int MARK_COUNT = 4;

    typedef enum logic [1:0] {
        MK_BLANK    = 2'd0,
        MK_SYNC_ON  = 2'd1,
        MK_SYNC_OFF = 2'd2,
        MK_WRAP     = 2'd3
    } mark_e;

    typedef struct packed {
        logic active;
        logic sync;
    } axis_flags_t;

    // Advance a Fibonacci shift register of the given width by a number of steps.
    function automatic logic [31:0] lfsr_jump(
        input logic [31:0] seed,
        input logic [31:0] taps,
        input int          width,
        input int          steps
    );
        logic [31:0] s;
        logic [31:0] wmask;
        logic        fb;
        wmask = (32'd1 << width) - 32'd1;
        s     = seed & wmask;
        for (int i = 0; i < steps; i++) begin
            fb = ^(s & taps);
            s  = ((s << 1) | {31'd0, fb}) & wmask;
        end
        return s;
    endfunction

    function automatic int mark_steps(
        input int k,
        input int active_len,
        input int sync_begin,
        input int sync_end,
        input int total_len
    );
        if (k == int'(MK_BLANK))        return active_len - 1;
        else if (k == int'(MK_SYNC_ON)) return sync_begin - 1;
        else if (k == int'(MK_SYNC_OFF)) return sync_end - 1;
        else                             return total_len - 1;
    endfunction

endpackage

// File: rtl/raster_axis.sv
module raster_axis
    import raster_pkg::*;
#(
    parameter int               WIDTH      = 9,
    parameter logic [WIDTH-1:0] TAPS       = 9'h110,
    parameter logic [WIDTH-1:0] SEED       = 9'h001,
    parameter int               ACTIVE_LEN = 288,
    parameter int               SYNC_BEGIN = 308,
    parameter int               SYNC_END   = 353,
    parameter int               TOTAL_LEN  = 381
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        adv,
    output logic        wrap_o,
    output axis_flags_t flags_o
);

    logic [WIDTH-1:0]      state_q;
    logic [MARK_COUNT-1:0] hit;
    axis_flags_t           flags_q;

    // One equality comparator per timing mark against a precomputed LFSR state
    for (genvar k = 0; k < MARK_COUNT; k++) begin : g_mark
        localparam int          STEPS = mark_steps(k, ACTIVE_LEN, SYNC_BEGIN, SYNC_END, TOTAL_LEN);
        localparam logic [31:0] FULL  = lfsr_jump(32'(SEED), 32'(TAPS), WIDTH, STEPS);
        localparam logic [WIDTH-1:0] PAT = FULL[WIDTH-1:0];
        assign hit[k] = (state_q == PAT);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEED;
        end else if (adv) begin
            if (hit[MK_WRAP]) state_q <= SEED;
            else              state_q <= {state_q[WIDTH-2:0], ^(state_q & TAPS)};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q.active <= 1'b1;
            flags_q.sync   <= 1'b0;
        end else if (adv) begin
            if (hit[MK_BLANK])    flags_q.active <= 1'b0;
            if (hit[MK_WRAP])     flags_q.active <= 1'b1;
            if (hit[MK_SYNC_ON])  flags_q.sync   <= 1'b1;
            if (hit[MK_SYNC_OFF]) flags_q.sync   <= 1'b0;
        end
    end

    assign wrap_o  = adv & hit[MK_WRAP];
    assign flags_o = flags_q;

    initial a_len_fits_r4: assert (TOTAL_LEN < (1 << WIDTH) && SYNC_END < TOTAL_LEN
                                   && ACTIVE_LEN <= SYNC_BEGIN && SYNC_BEGIN < SYNC_END);

    p_state_nonzero_r4: assert property (@(posedge clk) disable iff (rst)
        state_q != '0);

    p_wrap_reload_r4: assert property (@(posedge clk) disable iff (rst)
        wrap_o |=> state_q == SEED);

    p_active_from_origin_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(flags_q.active) |-> state_q == SEED);

    p_sync_while_blank_r3: assert property (@(posedge clk) disable iff (rst)
        flags_q.sync |-> !flags_q.active);

    p_hold_without_adv_r5: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(state_q) && $stable(flags_q));

endmodule

// File: rtl/raster_sync_gen.sv
module raster_sync_gen
    import raster_pkg::*;
#(
    parameter int                 H_WIDTH      = 9,
    parameter logic [H_WIDTH-1:0] H_TAPS       = 9'h110,
    parameter logic [H_WIDTH-1:0] H_SEED       = 9'h001,
    parameter int                 H_ACTIVE     = 288,
    parameter int                 H_SYNC_START = 308,
    parameter int                 H_SYNC_END   = 353,
    parameter int                 H_TOTAL      = 381,
    parameter int                 V_WIDTH      = 10,
    parameter logic [V_WIDTH-1:0] V_TAPS       = 10'h240,
    parameter logic [V_WIDTH-1:0] V_SEED       = 10'h001,
    parameter int                 V_ACTIVE     = 455,
    parameter int                 V_SYNC_START = 486,
    parameter int                 V_SYNC_END   = 488,
    parameter int                 V_TOTAL      = 528
) (
    input  logic clk,
    input  logic rst,
    output logic hsync,
    output logic vsync,
    output logic h_active,
    output logic v_active,
    output logic video_on,
    output logic frame_start
);

    axis_flags_t h_flags;
    axis_flags_t v_flags;
    logic        h_wrap;
    logic        v_wrap;
    logic        frame_q;

    raster_axis #(
        .WIDTH(H_WIDTH), .TAPS(H_TAPS), .SEED(H_SEED),
        .ACTIVE_LEN(H_ACTIVE), .SYNC_BEGIN(H_SYNC_START),
        .SYNC_END(H_SYNC_END), .TOTAL_LEN(H_TOTAL)
    ) u_h (
        .clk(clk), .rst(rst), .adv(1'b1),
        .wrap_o(h_wrap), .flags_o(h_flags)
    );

    raster_axis #(
        .WIDTH(V_WIDTH), .TAPS(V_TAPS), .SEED(V_SEED),
        .ACTIVE_LEN(V_ACTIVE), .SYNC_BEGIN(V_SYNC_START),
        .SYNC_END(V_SYNC_END), .TOTAL_LEN(V_TOTAL)
    ) u_v (
        .clk(clk), .rst(rst), .adv(h_wrap),
        .wrap_o(v_wrap), .flags_o(v_flags)
    );

    always_ff @(posedge clk) begin
        if (rst) frame_q <= 1'b0;
        else     frame_q <= h_wrap & v_wrap;
    end

    assign hsync       = h_flags.sync;
    assign vsync       = v_flags.sync;
    assign h_active    = h_flags.active;
    assign v_active    = v_flags.active;
    assign video_on    = h_flags.active & v_flags.active;
    assign frame_start = frame_q;

    p_reset_origin_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> h_active && v_active && !hsync && !vsync && !frame_start);

    p_frame_single_r7: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> !frame_start);

    p_frame_at_origin_r7: assert property (@(posedge clk) disable iff (rst)
        frame_start |-> h_active && v_active && !hsync && !vsync);

    p_vsync_blank_r6: assert property (@(posedge clk) disable iff (rst)
        vsync |-> !v_active);

    p_line_wrap_enables_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(v_active) |-> $rose(h_active));

endmodule

// File: tb/raster_sync_gen_tb.sv
`timescale 1ns/1ps
module raster_sync_gen_tb;

    localparam int S_HA = 10, S_HS = 12, S_HE = 15, S_HT = 20;
    localparam int S_VA = 6,  S_VS = 8,  S_VE = 9,  S_VT = 11;
    localparam int F_HA = 288, F_HS = 308, F_HE = 353, F_HT = 381;

    logic clk = 1'b0;
    logic rst = 1'b1;
    int   checks = 0;
    int   failures = 0;

    logic s_hs, s_vs, s_ha, s_va, s_vo, s_fs;
    logic f_hs, f_vs, f_ha, f_va, f_vo, f_fs;

    always #2.5 clk = ~clk;

    raster_sync_gen #(
        .H_ACTIVE(S_HA), .H_SYNC_START(S_HS), .H_SYNC_END(S_HE), .H_TOTAL(S_HT),
        .V_ACTIVE(S_VA), .V_SYNC_START(S_VS), .V_SYNC_END(S_VE), .V_TOTAL(S_VT)
    ) u_dut (
        .clk(clk), .rst(rst), .hsync(s_hs), .vsync(s_vs), .h_active(s_ha),
        .v_active(s_va), .video_on(s_vo), .frame_start(s_fs)
    );

    raster_sync_gen u_full (
        .clk(clk), .rst(rst), .hsync(f_hs), .vsync(f_vs), .h_active(f_ha),
        .v_active(f_va), .video_on(f_vo), .frame_start(f_fs)
    );

    task automatic chk(input logic got, input logic exp, input string req,
                       input string what, input int n);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s %s n=%0d actual=%0b expected=%0b", req, what, n, got, exp);
        end
    endtask

    task automatic check_reset();
        chk(s_ha, 1'b1, "R1", "small h_active", -1);
        chk(s_va, 1'b1, "R1", "small v_active", -1);
        chk(s_vo, 1'b1, "R1", "small video_on", -1);
        chk(s_hs, 1'b0, "R1", "small hsync", -1);
        chk(s_vs, 1'b0, "R1", "small vsync", -1);
        chk(s_fs, 1'b0, "R1", "small frame_start", -1);
        chk(f_ha, 1'b1, "R1", "full h_active", -1);
        chk(f_hs, 1'b0, "R1", "full hsync", -1);
        chk(f_fs, 1'b0, "R1", "full frame_start", -1);
    endtask

    task automatic check_small(input int n, input bit restart);
        int h, v;
        logic eha, eva;
        string th, tv;
        h   = n % S_HT;
        v   = (n / S_HT) % S_VT;
        eha = (h < S_HA);
        eva = (v < S_VA);
        th  = (restart && n < 2 * S_HT) ? "R9" : ((h == 0 && n > 0) ? "R4" : "R2");
        tv  = (restart && n < 2 * S_HT) ? "R9" : "R5";
        chk(s_ha, eha, th, "small h_active", n);
        chk(s_hs, (h >= S_HS && h < S_HE), restart ? "R9" : "R3", "small hsync", n);
        chk(s_va, eva, tv, "small v_active", n);
        chk(s_vs, (v >= S_VS && v < S_VE), "R6", "small vsync", n);
        chk(s_fs, (n > 0 && h == 0 && v == 0), "R7", "small frame_start", n);
        chk(s_vo, eha & eva, "R8", "small video_on", n);
    endtask

    task automatic check_full(input int n);
        int h;
        h = n % F_HT;
        chk(f_ha, (h < F_HA), (h == 0 && n > 0) ? "R4" : "R2", "full h_active", n);
        chk(f_hs, (h >= F_HS && h < F_HE), "R3", "full hsync", n);
        chk(f_va, 1'b1, "R5", "full v_active", n);
        chk(f_vs, 1'b0, "R6", "full vsync", n);
        chk(f_fs, 1'b0, "R7", "full frame_start", n);
        chk(f_vo, (h < F_HA), "R8", "full video_on", n);
    endtask

    initial begin
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_reset();
        rst = 1'b0;
        for (int n = 0; n < 1200; n++) begin
            check_small(n, 1'b0);
            check_full(n);
            @(negedge clk);
        end
        // R9: reset mid-frame, then sweep again from the origin
        rst = 1'b1;
        @(negedge clk);
        check_reset();
        rst = 1'b0;
        for (int n = 0; n < 500; n++) begin
            check_small(n, 1'b1);
            check_full(n);
            @(negedge clk);
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(100000 * 5);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule